// File: doc/BRIEF.md
# Stochastic Multiply Write Sequencer

This controller runs one stochastic multiplication on a bank of memory rows whose bits switch with a probability set by how long a write pulse lasts. It accepts two 10-bit operands over a valid/ready handshake. A single shared lookup stage turns each operand into a log-scaled pulse length. The controller then drives one write-enable line whose polarity can be selected. First comes a reverse-polarity preset pulse that sets every selected bit to one. Next is a forward pulse sized from the first operand. Last is a forward pulse sized from the second operand, applied to the same rows with no preset in between. The fraction of bits that are still one then represents the product.

After the second pulse, the sequencer raises a request to an external pop-count unit. It stays busy until that unit acknowledges. A row mask chosen at the handshake selects several rows at once, so that more stochastic bits are written in parallel. The second operand is looked up during the cycles in which the first operand's pulse is being driven, so the lookup adds no time between the pulses.

Top module: `smw_seq`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. An operand pair is taken on a clock edge where both `in_valid` and `in_ready` are high. From the next cycle, `busy` is high and `in_ready` is low until the acknowledge is taken.
- R2: The first write pulse of every operation has `wr_pol` = 1 (reverse, preset to one). It lasts `preset_len` cycles, or `MAX_PULSE`+1 cycles if `preset_len` is not larger than `MAX_PULSE`. A reverse pulse is therefore always longer than any operand pulse.
- R3: An operand x maps to a forward pulse of ((F − g) · `MAX_PULSE`) / F cycles, with the division truncated. Here F = `OP_W`·2^`FRAC_W`. The value g = p·2^`FRAC_W` + floor((x+1 − 2^p)·2^`FRAC_W` / 2^p), where p is the position of the highest set bit of x+1.
- R4: Operand 0 gives a forward pulse of exactly `MAX_PULSE` cycles. The full-scale operand (all ones) gives no enabled cycle. No forward pulse is ever longer than `MAX_PULSE` cycles.
- R5: The phase order is fixed: one lookup cycle, then the preset, then one idle cycle, then the first-operand phase, then one idle cycle, then the second-operand phase. Each operand phase lasts max(L,1) cycles with `wr_en` high for L of them. No preset is driven between the two operand pulses.
- R6: The second operand's lookup takes place during the first operand's phase. The number of cycles from the handshake to `pc_req` is therefore P + max(La,1) + max(Lb,1) + 3.
- R7: Whenever `wr_en` is high, `row_sel` equals the mask taken at the handshake. `row_sel` is zero while idle and while waiting for the acknowledge.
- R8: `pc_req` rises when the second-operand phase ends and holds until `pc_done` is seen. The cycle after that, the block is idle with `pc_req` low.
- R9: Changes to `mul_a`, `mul_b`, `row_mask`, `preset_len` or `in_valid` while busy have no effect on the running operation's pulse lengths or rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take a pair |
| mul_a | input | OP_W | First operand |
| mul_b | input | OP_W | Second operand |
| row_mask | input | ROWS | Rows to write in parallel |
| preset_len | input | PRE_W | Requested preset pulse length in cycles |
| row_sel | output | ROWS | Row selects toward the array |
| wr_en | output | 1 | Write pulse enable, fixed amplitude |
| wr_pol | output | 1 | 1 = reverse (preset) polarity, 0 = forward |
| pc_req | output | 1 | Request to the pop-count unit |
| pc_done | input | 1 | Acknowledge from the pop-count unit |
| busy | output | 1 | Operation in progress |

## Verification
Two things happen in the same cycle: the lookup of the second operand and the first cycle of the first operand's pulse phase. The bench provokes this at both extremes. In one case the first operand is at full scale, so the phase is a single cycle holding only the lookup. In the other case it is zero, giving the longest pulse. The bench also changes the operand inputs in mid-operation. It judges the result by two things: the exact cycle count from the handshake to the pop-count request, and whether the second pulse length matches the mapping of the operand accepted at the handshake.

// File: rtl/smw_pkg.sv
`timescale 1ns/1ps
package smw_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_LUTA, S_PRE, S_GAP1, S_OPA, S_GAP2, S_OPB, S_WAIT
  } seq_state_t;

  // Fixed-point log2 of v: integer part = position of the top set bit,
  // fraction = the fw bits just below it.
  function automatic int unsigned log_fix(input int unsigned v,
                                          input int unsigned opw,
                                          input int unsigned fw);
    int unsigned p;
    int unsigned t;
    int unsigned frac;
    p = 0;
    for (int i = 0; i < 32; i++)
      if ((v >> i) != 0) p = i;
    t    = v << (opw - p);
    frac = (t >> (opw - fw)) & ((32'd1 << fw) - 32'd1);
    return (p << fw) | frac;
  endfunction

  // Forward pulse length for operand x: scaled distance of log2(x+1) from full scale.
  function automatic int unsigned pulse_cycles(input int unsigned x,
                                               input int unsigned opw,
                                               input int unsigned fw,
                                               input int unsigned maxp);
    int unsigned full;
    int unsigned lg;
    full = opw << fw;
    lg   = log_fix(x + 32'd1, opw, fw);
    return ((full - lg) * maxp) / full;
  endfunction

  // Preset length with a floor one cycle above the longest operand pulse.
  function automatic int unsigned preset_cycles(input int unsigned req,
                                                input int unsigned maxp);
    return (req > maxp) ? req : maxp + 32'd1;
  endfunction

endpackage

// File: rtl/smw_loglut.sv
`timescale 1ns/1ps
module smw_loglut
  import smw_pkg::*;
#(
  parameter int OP_W      = 10,
  parameter int FRAC_W    = 4,
  parameter int MAX_PULSE = 40,
  parameter int LEN_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              slot,
  input  logic [OP_W-1:0]   operand,
  output logic [LEN_W-1:0]  len_a,
  output logic [LEN_W-1:0]  len_b
);

  logic [LEN_W-1:0] code;
  logic [LEN_W-1:0] len_q [2];

  always_comb
    code = LEN_W'(pulse_cycles(32'(operand), OP_W, FRAC_W, MAX_PULSE));

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        len_q[g] <= '0;
      else if (load && (slot == 1'(g)))
        len_q[g] <= code;
    end
  end

  assign len_a = len_q[0];
  assign len_b = len_q[1];

endmodule

// File: rtl/smw_pulse_timer.sv
`timescale 1ns/1ps
module smw_pulse_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] rem,
  output logic             active,
  output logic             last
);

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      rem_q <= '0;
    else if (load)
      rem_q <= len;
    else if (rem_q != '0)
      rem_q <= rem_q - CNT_W'(1);
  end

  assign rem    = rem_q;
  assign active = (rem_q != '0);
  assign last   = (rem_q <= CNT_W'(1));

endmodule

// File: rtl/smw_ctrl.sv
`timescale 1ns/1ps
module smw_ctrl
  import smw_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             pc_done,
  input  logic             tmr_last,
  input  logic [CNT_W-1:0] preset_cyc,
  input  logic [LEN_W-1:0] len_a,
  input  logic [LEN_W-1:0] len_b,
  output logic             in_ready,
  output logic             busy,
  output logic             lut_load,
  output logic             lut_slot,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             drive_phase,
  output logic             rows_on,
  output logic             pol_rev,
  output logic             pc_req,
  output logic             ev_accept,
  output logic             ev_lut_b,
  output seq_state_t       state_o
);

  seq_state_t st, nxt;
  logic       b_done;

  always_comb begin
    nxt      = st;
    lut_load = 1'b0;
    lut_slot = 1'b0;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (st)
      S_IDLE: if (in_valid) nxt = S_LUTA;
      S_LUTA: begin
        lut_load = 1'b1;
        tmr_load = 1'b1;
        tmr_len  = preset_cyc;
        nxt      = S_PRE;
      end
      S_PRE:  if (tmr_last) nxt = S_GAP1;
      S_GAP1: begin
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(len_a);
        nxt      = S_OPA;
      end
      S_OPA: begin
        if (!b_done) begin
          lut_load = 1'b1;
          lut_slot = 1'b1;
        end
        if (tmr_last) nxt = S_GAP2;
      end
      S_GAP2: begin
        tmr_load = 1'b1;
        tmr_len  = CNT_W'(len_b);
        nxt      = S_OPB;
      end
      S_OPB:  if (tmr_last) nxt = S_WAIT;
      S_WAIT: if (pc_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      b_done <= 1'b0;
    end else begin
      st <= nxt;
      if (ev_accept)
        b_done <= 1'b0;
      else if (st == S_OPA)
        b_done <= 1'b1;
    end
  end

  assign in_ready    = (st == S_IDLE);
  assign busy        = (st != S_IDLE);
  assign ev_accept   = in_ready && in_valid;
  assign ev_lut_b    = lut_load && lut_slot;
  assign drive_phase = (st == S_PRE) || (st == S_OPA) || (st == S_OPB);
  assign rows_on     = (st == S_PRE) || (st == S_GAP1) || (st == S_OPA) ||
                       (st == S_GAP2) || (st == S_OPB);
  assign pol_rev     = (st == S_PRE);
  assign pc_req      = (st == S_WAIT);
  assign state_o     = st;

endmodule

// File: rtl/smw_seq.sv
`timescale 1ns/1ps
module smw_seq
  import smw_pkg::*;
#(
  parameter int OP_W      = 10,
  parameter int FRAC_W    = 4,
  parameter int MAX_PULSE = 40,
  parameter int PRE_W     = 8,
  parameter int ROWS      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  mul_a,
  input  logic [OP_W-1:0]  mul_b,
  input  logic [ROWS-1:0]  row_mask,
  input  logic [PRE_W-1:0] preset_len,
  output logic [ROWS-1:0]  row_sel,
  output logic             wr_en,
  output logic             wr_pol,
  output logic             pc_req,
  input  logic             pc_done,
  output logic             busy
);

  localparam int LEN_W = $clog2(MAX_PULSE + 1);
  localparam int CNT_W = ((PRE_W > LEN_W) ? PRE_W : LEN_W) + 1;

  logic [OP_W-1:0]  a_q, b_q;
  logic [ROWS-1:0]  mask_q;
  logic [CNT_W-1:0] preset_q;

  logic             lut_load, lut_slot;
  logic [LEN_W-1:0] len_a, len_b;
  logic             tmr_load, tmr_active, tmr_last;
  logic [CNT_W-1:0] tmr_len, tmr_rem;
  logic             drive_phase, rows_on, pol_rev;
  logic             ev_accept, ev_lut_b;
  seq_state_t       state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q      <= '0;
      b_q      <= '0;
      mask_q   <= '0;
      preset_q <= '0;
    end else if (ev_accept) begin
      a_q      <= mul_a;
      b_q      <= mul_b;
      mask_q   <= row_mask;
      preset_q <= CNT_W'(preset_cycles(32'(preset_len), MAX_PULSE));
    end
  end

  smw_loglut #(
    .OP_W(OP_W), .FRAC_W(FRAC_W), .MAX_PULSE(MAX_PULSE), .LEN_W(LEN_W)
  ) u_lut (
    .clk(clk), .rst_n(rst_n), .load(lut_load), .slot(lut_slot),
    .operand(lut_slot ? b_q : a_q), .len_a(len_a), .len_b(len_b)
  );

  smw_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len),
    .rem(tmr_rem), .active(tmr_active), .last(tmr_last)
  );

  smw_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_done(pc_done),
    .tmr_last(tmr_last), .preset_cyc(preset_q), .len_a(len_a), .len_b(len_b),
    .in_ready(in_ready), .busy(busy), .lut_load(lut_load), .lut_slot(lut_slot),
    .tmr_load(tmr_load), .tmr_len(tmr_len), .drive_phase(drive_phase),
    .rows_on(rows_on), .pol_rev(pol_rev), .pc_req(pc_req),
    .ev_accept(ev_accept), .ev_lut_b(ev_lut_b), .state_o(state)
  );

  assign wr_en  = drive_phase && tmr_active;
  assign wr_pol = pol_rev;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_sel[r] = rows_on && mask_q[r];
  end

endmodule

// File: rtl/smw_seq_chk.sv
`timescale 1ns/1ps
module smw_seq_chk #(
  parameter int MAX_PULSE = 40,
  parameter int ROWS      = 8,
  parameter int CNT_W     = 9,
  parameter int LEN_W     = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             wr_en,
  input logic             wr_pol,
  input logic [ROWS-1:0]  row_sel,
  input logic             pc_req,
  input logic             pc_done,
  input logic             ev_accept,
  input logic             ev_lut_b,
  input logic [CNT_W-1:0] tmr_rem,
  input logic [LEN_W-1:0] len_a
);

  logic        pre_act, pre_act_q, fwd_act, pre_seen;
  logic [15:0] pre_run, fwd_run;

  assign pre_act = wr_en && wr_pol;
  assign fwd_act = wr_en && !wr_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_act_q <= 1'b0;
      pre_run   <= '0;
      fwd_run   <= '0;
      pre_seen  <= 1'b0;
    end else begin
      pre_act_q <= pre_act;
      pre_run   <= pre_act ? pre_run + 16'd1 : 16'd0;
      fwd_run   <= fwd_act ? fwd_run + 16'd1 : 16'd0;
      if (ev_accept)    pre_seen <= 1'b0;
      else if (pre_act) pre_seen <= 1'b1;
    end
  end

  p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  p_preset_long_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_act_q && !pre_act) |-> (pre_run > 16'(MAX_PULSE)));

  p_fwd_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_run <= 16'(MAX_PULSE));

  p_preset_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_act |-> pre_seen);

  p_lutb_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lut_b |-> (tmr_rem == CNT_W'(len_a)));

  p_rows_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (row_sel == '0));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_req && !pc_done) |=> pc_req);

endmodule

bind smw_seq smw_seq_chk #(
  .MAX_PULSE(MAX_PULSE), .ROWS(ROWS), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .wr_en(wr_en), .wr_pol(wr_pol), .row_sel(row_sel),
  .pc_req(pc_req), .pc_done(pc_done), .ev_accept(ev_accept),
  .ev_lut_b(ev_lut_b), .tmr_rem(tmr_rem), .len_a(len_a)
);

// File: tb/smw_seq_tb.sv
`timescale 1ns/1ps
module smw_seq_tb;
  localparam int OPW = 10;
  localparam int FW  = 4;
  localparam int MAXP = 40;
  localparam int PW  = 8;
  localparam int NR  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [OPW-1:0] mul_a = '0, mul_b = '0;
  logic [NR-1:0]  row_mask = '0;
  logic [PW-1:0]  preset_len = '0;
  logic [NR-1:0]  row_sel;
  logic wr_en, wr_pol, pc_req, busy;
  logic pc_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  smw_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mul_a(mul_a), .mul_b(mul_b), .row_mask(row_mask), .preset_len(preset_len),
    .row_sel(row_sel), .wr_en(wr_en), .wr_pol(wr_pol), .pc_req(pc_req),
    .pc_done(pc_done), .busy(busy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Mapping restated: integer log by repeated doubling, fraction by division.
  function automatic int exp_len(input int x);
    int v, p, frac, g, full;
    v = x + 1;
    p = 0;
    while ((1 << (p + 1)) <= v) p++;
    frac = ((v - (1 << p)) * (1 << FW)) / (1 << p);
    g = p * (1 << FW) + frac;
    full = OPW * (1 << FW);
    return ((full - g) * MAXP) / full;
  endfunction

  function automatic int exp_pre(input int req);
    return (req > MAXP) ? req : MAXP + 1;
  endfunction

  task automatic do_mul(input int a, input int b, input logic [NR-1:0] m,
                        input int pl, input int ack_wait, input bit scramble);
    int la, lb, ep, cyc, pre, seg, revafter, badrows, badready, nseg;
    int lens[2];
    bit prev_fwd;
    la = exp_len(a);
    lb = exp_len(b);
    ep = exp_pre(pl);
    @(negedge clk);
    mul_a = OPW'(a); mul_b = OPW'(b); row_mask = m; preset_len = PW'(pl);
    in_valid = 1'b1;
    chk(in_ready == 1'b1, "R1 ready before handshake", int'(in_ready), 1);
    @(negedge clk);
    if (scramble) begin
      mul_a = ~OPW'(a); mul_b = ~OPW'(b); row_mask = ~m; preset_len = 8'd255;
    end else begin
      in_valid = 1'b0;
    end
    chk(busy && !in_ready, "R1 busy after handshake", int'(busy), 1);
    cyc = 0; pre = 0; seg = 0; revafter = 0; badrows = 0; badready = 0;
    lens[0] = 0; lens[1] = 0; prev_fwd = 1'b0;
    while (!pc_req && cyc < 2000) begin
      if (in_ready) badready++;
      if (wr_en) begin
        if (row_sel != m) badrows++;
        if (wr_pol) begin
          pre++;
          if (seg > 0) revafter++;
        end else begin
          if (!prev_fwd) seg++;
          if (seg >= 1 && seg <= 2) lens[seg-1]++;
        end
      end
      prev_fwd = wr_en && !wr_pol;
      cyc++;
      @(negedge clk);
    end
    chk(pre == ep, "R2 preset length", pre, ep);
    chk(revafter == 0, "R5 no preset between operand pulses", revafter, 0);
    chk(cyc == ep + (la > 0 ? la : 1) + (lb > 0 ? lb : 1) + 3,
        "R6 handshake-to-request cycles", cyc,
        ep + (la > 0 ? la : 1) + (lb > 0 ? lb : 1) + 3);
    nseg = (la > 0 ? 1 : 0) + (lb > 0 ? 1 : 0);
    chk(seg == nseg, "R4 forward pulse count", seg, nseg);
    if (la > 0) begin
      chk(lens[0] == la, "R3 first operand pulse", lens[0], la);
      if (lb > 0) chk(lens[1] == lb, "R3 second operand pulse", lens[1], lb);
    end else if (lb > 0) begin
      chk(lens[0] == lb, "R3 second operand pulse alone", lens[0], lb);
    end
    chk(badrows == 0, "R7 rows during pulses", badrows, 0);
    if (scramble) chk(badready == 0, "R9 no ready while busy", badready, 0);
    chk(row_sel == '0, "R7 rows off while waiting", int'(row_sel), 0);
    for (int k = 0; k < ack_wait; k++) begin
      chk(pc_req && busy, "R8 request held", int'(pc_req), 1);
      @(negedge clk);
    end
    pc_done = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    pc_done = 1'b0;
    chk(!busy && in_ready && !pc_req, "R8 idle after acknowledge", int'(busy), 0);
    @(negedge clk);
    chk(!busy && !wr_en, "R9 no stale start", int'(busy), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !busy && !wr_en && !pc_req && row_sel == '0,
        "R1 reset state", int'(busy), 0);
    chk(exp_len(0) == MAXP, "R4 zero maps to maximum", exp_len(0), MAXP);
    do_mul(0, 0, 8'h0F, 60, 2, 1'b0);
    do_mul(1023, 1023, 8'hFF, 10, 0, 1'b0);
    do_mul(2, 511, 8'hA5, 200, 1, 1'b0);
    do_mul(1023, 1, 8'h3C, 41, 3, 1'b0);
    do_mul(300, 700, 8'h81, 50, 5, 1'b1);
    do_mul(0, 1023, 8'h01, 0, 0, 1'b0);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule